// File: doc/BRIEF.md
# Serial EEPROM Slave Front-End with 512-Byte Array

This block is the device side of a small serial EEPROM reached over SPI (mode 0: the serial clock idles low, input is sampled on its rising edge, output changes on its falling edge). A system clock oversamples the serial clock, chip select and hold inputs. The block shifts in an 8-bit command, decodes it, and then runs the address and data phases for array reads, array page writes, status reads and status writes. A write-enable latch guards every write. Two block-protect bits can fence off the upper part of the array.

The nonvolatile storage is modelled as a register file (512 x 8 by default) that accepts a whole page in one clock cycle. Write data collects in a page buffer. It reaches the array only when chip select is released exactly on a byte boundary, so an aborted transfer leaves the array untouched. For the 512-byte configuration the ninth address bit travels inside the command byte, so one address byte is enough. A hold input freezes the transfer mid-stream; it resumes from the same bit once hold is released.

Top module: `ee_spi_slave`

## Requirements
- R1: After reset the write-enable latch and both protect bits are 0, so a status read returns 0x00. Every array byte reads 0x00 and miso_oe is low.
- R2: A transfer samples mosi on each rising sck edge, most significant bit first. The first 8 bits form the command. A command whose upper nibble is not zero, or whose low three bits are 000 or 111, does nothing: miso_oe stays low and no state changes.
- R3: Command bits [2:0] = 110 sets the write-enable latch and 100 clears it, whatever bit 3 holds. Command 0000_x101 returns the status byte again and again while chip select stays low. In the status byte, bit 0 is always 0, bit 1 is the latch, bits 3:2 are the protect bits, and bits 7:4 are 0.
- R4: Command 0000_A011 followed by one address byte reads the array. A is address bit 8 and the address byte gives bits 7:0. The first data bit appears after the falling sck edge that follows the 16th rising edge. Reading goes on through consecutive addresses and wraps from 511 to 0.
- R5: Command 0000_A010 is accepted only while the latch is set. Without the latch, the address and data bytes that follow leave the array unchanged.
- R6: Write data is stored only if chip select rises after a whole number of data bytes, and at least one. If chip select rises mid-byte, the array is unchanged and the latch stays set.
- R7: Successive write bytes fill a 16-byte page and wrap to the start of the same page. They never spill into the next page.
- R8: A completed write (R6) or a completed status write (R9) clears the latch.
- R9: Command 0000_x001 followed by a data byte loads the protect bits from data bits 3:2 and ignores the other data bits. It has an effect only if the latch is set and wp_n is high when chip select rises. If wp_n is low, nothing changes, including the latch.
- R10: Protect bits 01 guard the top quarter of the array (384..511), 10 the top half, and 11 the whole array. A completed write into a guarded page is discarded but still clears the latch.
- R11: While hold_n is low, sck edges are ignored and miso_oe is low. Once hold_n is high again, shifting continues from the same bit.
- R12: miso_oe is high only while chip select is low, hold_n is high and a read or status-read data phase is active. miso changes only after a falling sck edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the master |
| mosi | input | 1 | Serial data into the block |
| hold_n | input | 1 | Pauses the transfer while low |
| wp_n | input | 1 | Write protect for status writes, active low |
| miso | output | 1 | Serial data out of the block |
| miso_oe | output | 1 | Output enable for miso; low means tri-stated |

## Verification
Releasing chip select at the end of a write does two things in the same clock: it decides the page commit against the protect bits, and it clears the write-enable latch. Likewise, a status write changes the protect bits and clears the latch in that same cycle. The bench triggers both cases by writing into a guarded page and by sending a status write with wp_n held low and then high. It then judges the result by reading the array byte and the status byte back in later transfers. Both must agree: the data is discarded while the latch clears, or the status is left unchanged while the latch stays set.

// File: rtl/ee_spi_pkg.sv
package ee_spi_pkg;

   // Low three bits of the command byte (upper nibble must be zero)
   localparam logic [2:0] CMD_READ  = 3'b011;
   localparam logic [2:0] CMD_WRITE = 3'b010;
   localparam logic [2:0] CMD_WDIS  = 3'b100;
   localparam logic [2:0] CMD_WEN   = 3'b110;
   localparam logic [2:0] CMD_SRD   = 3'b101;
   localparam logic [2:0] CMD_SWR   = 3'b001;

   typedef enum logic [2:0] {
      PH_CMD,
      PH_ADDR,
      PH_RDATA,
      PH_WDATA,
      PH_SRD,
      PH_SWR,
      PH_SKIP
   } phase_t;

endpackage

// File: rtl/ee_spi_edges.sv
module ee_spi_edges (
   input  logic clk,
   input  logic rst_n,
   input  logic sck,
   input  logic cs_n,
   input  logic hold_n,
   output logic rise_v,
   output logic fall_v,
   output logic cs_rise
);

   logic sck_d;
   logic cs_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d <= 1'b0;
         cs_d  <= 1'b1;
      end else begin
         sck_d <= sck;
         cs_d  <= cs_n;
      end
   end

   logic live;
   assign live    = !cs_n && hold_n;
   assign rise_v  = live && sck && !sck_d;
   assign fall_v  = live && !sck && sck_d;
   assign cs_rise = cs_n && !cs_d;

endmodule

// File: rtl/ee_spi_array.sv
module ee_spi_array #(
   parameter int DEPTH = 512,
   parameter int PAGE  = 16,
   localparam int AW   = $clog2(DEPTH),
   localparam int PW   = $clog2(PAGE),
   localparam int GW   = AW - PW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit,
   input  logic [GW-1:0]     cpage,
   input  logic [PAGE*8-1:0] cdata,
   input  logic [PAGE-1:0]   cmask,
   input  logic [AW-1:0]     raddr,
   output logic [7:0]        rdata
);

   logic [DEPTH-1:0][7:0] cells;

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      localparam int PG = i / PAGE;
      localparam int SL = i % PAGE;
      logic [7:0] val;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            val <= 8'h00;
         else if (commit && cpage == GW'(PG) && cmask[SL])
            val <= cdata[SL*8 +: 8];
      end
      assign cells[i] = val;
   end

   assign rdata = cells[raddr];

   AST_COMMIT_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> (cmask != '0)); // R6

endmodule

// File: rtl/ee_spi_ctrl.sv
module ee_spi_ctrl
   import ee_spi_pkg::*;
#(
   parameter int DEPTH = 512,
   parameter int PAGE  = 16,
   localparam int AW   = $clog2(DEPTH),
   localparam int PW   = $clog2(PAGE),
   localparam int GW   = AW - PW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              hold_n,
   input  logic              mosi,
   input  logic              wp_n,
   input  logic              rise_v,
   input  logic              fall_v,
   input  logic              cs_rise,
   input  logic [7:0]        rdata,
   output logic [AW-1:0]     raddr,
   output logic              commit,
   output logic [GW-1:0]     cpage,
   output logic [PAGE*8-1:0] cdata,
   output logic [PAGE-1:0]   cmask,
   output logic              miso,
   output logic              miso_oe
);

   initial begin
      assert (DEPTH >= 16 && DEPTH <= 512 && (1 << AW) == DEPTH)
         else $error("DEPTH must be a power of two in 16..512");
      assert (PAGE >= 2 && (1 << PW) == PAGE && DEPTH >= 4 * PAGE)
         else $error("PAGE must be a power of two with DEPTH >= 4*PAGE");
   end

   phase_t                ph;
   logic [2:0]            bc;
   logic [7:0]            sh;
   logic [2:0]            ob;
   logic [AW-1:0]         addr;
   logic                  is_rd;
   logic                  a8_q;
   logic                  wel;
   logic [1:0]            bp;
   logic [1:0]            sr_new;
   logic                  sr_have;
   logic                  wr_have;
   logic                  miso_q;
   logic [PAGE-1:0][7:0]  pbuf;
   logic [PAGE-1:0]       pmask;

   logic [7:0] byte_now;
   logic [7:0] status;
   logic [7:0] out_byte;
   logic [AW-1:0] addr_in;

   assign byte_now = {sh[6:0], mosi};
   assign status   = {4'b0000, bp, wel, 1'b0};
   assign out_byte = (ph == PH_RDATA) ? rdata : status;

   // Address assembly: ninth bit from the command byte only in the 512-byte variant
   if (AW == 9) begin : g_addr_hi
      assign addr_in = {a8_q, byte_now};
   end else begin : g_addr_lo
      logic unused_hi;
      assign unused_hi = a8_q ^ (^byte_now[7:AW]);
      assign addr_in = byte_now[AW-1:0];
   end

   // Protection limit from the block-protect bits (compare page base)
   logic [AW:0] lim;
   logic        prot;
   always_comb begin
      case (bp)
         2'b00:   lim = (AW+1)'(DEPTH);
         2'b01:   lim = (AW+1)'(DEPTH - DEPTH / 4);
         2'b10:   lim = (AW+1)'(DEPTH / 2);
         default: lim = '0;
      endcase
   end
   assign prot = {1'b0, addr[AW-1:PW], PW'(0)} >= lim;

   logic wr_done;
   logic sr_done;
   assign wr_done = cs_rise && ph == PH_WDATA && bc == 3'd0 && wr_have;
   assign sr_done = cs_rise && ph == PH_SWR && bc == 3'd0 && sr_have && wp_n;

   assign commit  = wr_done && !prot;
   assign cpage   = addr[AW-1:PW];
   assign cdata   = pbuf;
   assign cmask   = pmask;
   assign raddr   = addr;
   assign miso    = miso_q;
   assign miso_oe = !cs_n && hold_n && (ph == PH_RDATA || ph == PH_SRD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph      <= PH_CMD;
         bc      <= 3'd0;
         sh      <= 8'h00;
         ob      <= 3'd0;
         addr    <= '0;
         is_rd   <= 1'b0;
         a8_q    <= 1'b0;
         wel     <= 1'b0;
         bp      <= 2'b00;
         sr_new  <= 2'b00;
         sr_have <= 1'b0;
         wr_have <= 1'b0;
         miso_q  <= 1'b0;
         pbuf    <= '0;
         pmask   <= '0;
      end else if (cs_n) begin
         if (wr_done || sr_done) wel <= 1'b0;
         if (sr_done) bp <= sr_new;
         ph      <= PH_CMD;
         bc      <= 3'd0;
         ob      <= 3'd0;
         sr_have <= 1'b0;
         wr_have <= 1'b0;
      end else begin
         if (rise_v) begin
            bc <= bc + 3'd1;
            sh <= byte_now;
            if (bc == 3'd7) begin
               case (ph)
                  PH_CMD: begin
                     a8_q <= byte_now[3];
                     if (byte_now[7:4] != 4'h0) begin
                        ph <= PH_SKIP;
                     end else begin
                        case (byte_now[2:0])
                           CMD_READ:  begin ph <= PH_ADDR; is_rd <= 1'b1; end
                           CMD_WRITE: begin
                              ph    <= wel ? PH_ADDR : PH_SKIP;
                              is_rd <= 1'b0;
                           end
                           CMD_WEN:   begin wel <= 1'b1; ph <= PH_SKIP; end
                           CMD_WDIS:  begin wel <= 1'b0; ph <= PH_SKIP; end
                           CMD_SRD:   ph <= PH_SRD;
                           CMD_SWR:   ph <= wel ? PH_SWR : PH_SKIP;
                           default:   ph <= PH_SKIP;
                        endcase
                     end
                  end
                  PH_ADDR: begin
                     addr  <= addr_in;
                     pmask <= '0;
                     ph    <= is_rd ? PH_RDATA : PH_WDATA;
                  end
                  PH_WDATA: begin
                     pbuf[addr[PW-1:0]]  <= byte_now;
                     pmask[addr[PW-1:0]] <= 1'b1;
                     addr    <= {addr[AW-1:PW], addr[PW-1:0] + PW'(1)};
                     wr_have <= 1'b1;
                  end
                  PH_SWR: begin
                     if (!sr_have) begin
                        sr_new  <= byte_now[3:2];
                        sr_have <= 1'b1;
                     end
                  end
                  default: ;
               endcase
            end
         end
         if (fall_v && (ph == PH_RDATA || ph == PH_SRD)) begin
            miso_q <= out_byte[3'd7 - ob];
            ob     <= ob + 3'd1;
            if (ob == 3'd7 && ph == PH_RDATA) addr <= addr + AW'(1);
         end
      end
   end

   AST_WEL_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wel) |-> $past(rise_v)); // R3

   AST_NO_COMMIT_WO_WEL: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> wel); // R5

   AST_BP_NEEDS_WP: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(bp) |-> $past(wp_n)); // R9

   AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && !hold_n) |=> ($stable(bc) && $stable(sh) && $stable(miso_q))); // R11

   AST_MISO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(miso_q) |-> $past(fall_v)); // R12

endmodule

// File: rtl/ee_spi_slave.sv
module ee_spi_slave #(
   parameter int DEPTH = 512,
   parameter int PAGE  = 16,
   localparam int AW   = $clog2(DEPTH),
   localparam int PW   = $clog2(PAGE),
   localparam int GW   = AW - PW
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sck,
   input  logic mosi,
   input  logic hold_n,
   input  logic wp_n,
   output logic miso,
   output logic miso_oe
);

   logic              rise_v;
   logic              fall_v;
   logic              cs_rise;
   logic [AW-1:0]     raddr;
   logic [7:0]        rdata;
   logic              commit;
   logic [GW-1:0]     cpage;
   logic [PAGE*8-1:0] cdata;
   logic [PAGE-1:0]   cmask;

   ee_spi_edges u_edges (
      .clk     (clk),
      .rst_n   (rst_n),
      .sck     (sck),
      .cs_n    (cs_n),
      .hold_n  (hold_n),
      .rise_v  (rise_v),
      .fall_v  (fall_v),
      .cs_rise (cs_rise)
   );

   ee_spi_ctrl #(.DEPTH(DEPTH), .PAGE(PAGE)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs_n    (cs_n),
      .hold_n  (hold_n),
      .mosi    (mosi),
      .wp_n    (wp_n),
      .rise_v  (rise_v),
      .fall_v  (fall_v),
      .cs_rise (cs_rise),
      .rdata   (rdata),
      .raddr   (raddr),
      .commit  (commit),
      .cpage   (cpage),
      .cdata   (cdata),
      .cmask   (cmask),
      .miso    (miso),
      .miso_oe (miso_oe)
   );

   ee_spi_array #(.DEPTH(DEPTH), .PAGE(PAGE)) u_array (
      .clk    (clk),
      .rst_n  (rst_n),
      .commit (commit),
      .cpage  (cpage),
      .cdata  (cdata),
      .cmask  (cmask),
      .raddr  (raddr),
      .rdata  (rdata)
   );

   AST_OE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n || !hold_n) |-> !miso_oe); // R11

endmodule

// File: tb/sim_ee_spi_slave.sv
`timescale 1ns/1ps
module sim_ee_spi_slave;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1;
   logic sck = 1'b0;
   logic mosi = 1'b0;
   logic hold_n = 1'b1;
   logic wp_n = 1'b1;
   logic miso;
   logic miso_oe;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   ee_spi_slave u0 (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
      .hold_n(hold_n), .wp_n(wp_n), .miso(miso), .miso_oe(miso_oe)
   );

   // {address[8:0], data[7:0]}
   localparam logic [16:0] VEC [5] = '{
      17'h0003C, 17'h0FFA5, 17'h1005A, 17'h1FFC3, 17'h07E81
   };

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic bitx(input logic b, output logic r);
      mosi = b;
      tick(3);
      r = miso;
      sck = 1'b1;
      tick(3);
      sck = 1'b0;
      tick(3);
   endtask

   task automatic byte_x(input logic [7:0] t, output logic [7:0] r);
      for (int i = 7; i >= 0; i--) bitx(t[i], r[i]);
   endtask

   task automatic sel();
      cs_n = 1'b0;
      tick(3);
   endtask

   task automatic desel();
      cs_n = 1'b1;
      tick(3);
   endtask

   task automatic cmd1(input logic [7:0] op);
      logic [7:0] d;
      sel();
      byte_x(op, d);
      desel();
   endtask

   task automatic rdsr(output logic [7:0] s);
      logic [7:0] d;
      sel();
      byte_x(8'h05, d);
      byte_x(8'h00, s);
      desel();
   endtask

   task automatic wr1(input logic [8:0] a, input logic [7:0] v);
      logic [7:0] d;
      cmd1(8'h06);
      sel();
      byte_x(8'h02 | {4'h0, a[8], 3'b000}, d);
      byte_x(a[7:0], d);
      byte_x(v, d);
      desel();
   endtask

   task automatic rd1(input logic [8:0] a, output logic [7:0] v);
      logic [7:0] d;
      sel();
      byte_x(8'h03 | {4'h0, a[8], 3'b000}, d);
      byte_x(a[7:0], d);
      byte_x(8'h00, v);
      desel();
   endtask

   task automatic wrsr(input logic [7:0] v);
      logic [7:0] d;
      cmd1(8'h06);
      sel();
      byte_x(8'h01, d);
      byte_x(v, d);
      desel();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] v, v2, d;
      logic r;
      tick(4);
      rst_n = 1'b1;
      tick(4);

      // R1 reset state
      chk("R1 oe after reset", {7'd0, miso_oe}, 8'h00);
      rdsr(v);
      chk("R1 status after reset", v, 8'h00);
      rd1(9'h005, v);
      chk("R1 array after reset", v, 8'h00);

      // Table walk: write one byte, read it back, latch cleared
      for (int i = 0; i < 5; i++) begin
         wr1(VEC[i][16:8], VEC[i][7:0]);
         rd1(VEC[i][16:8], v);
         chk("R4 readback of written byte (R2 msb first)", v, VEC[i][7:0]);
         rdsr(v);
         chk("R8 latch cleared after write", v, 8'h00);
      end

      // R4 sequential read wrapping 511 -> 0
      sel();
      byte_x(8'h0B, d);
      byte_x(8'hFF, d);
      chk("R12 oe high in read data phase", {7'd0, miso_oe}, 8'h01);
      byte_x(8'h00, v);
      byte_x(8'h00, v2);
      desel();
      chk("R4 read at 511", v, 8'hC3);
      chk("R4 read wraps to 0", v2, 8'h3C);
      chk("R12 oe low after deselect", {7'd0, miso_oe}, 8'h00);

      // R3 latch set/clear and repeated status
      cmd1(8'h0E);
      sel();
      byte_x(8'h05, d);
      byte_x(8'h00, v);
      byte_x(8'h00, v2);
      desel();
      chk("R3 status with latch set", v, 8'h02);
      chk("R3 status repeats", v2, 8'h02);
      cmd1(8'h04);
      rdsr(v);
      chk("R3 latch cleared by disable", v, 8'h00);

      // R5 write without latch
      sel();
      byte_x(8'h02, d);
      byte_x(8'h10, d);
      byte_x(8'h77, d);
      desel();
      rd1(9'h010, v);
      chk("R5 write without latch ignored", v, 8'h00);

      // R6 chip select rises mid-byte
      cmd1(8'h06);
      sel();
      byte_x(8'h02, d);
      byte_x(8'h20, d);
      byte_x(8'h11, d);
      for (int i = 0; i < 4; i++) bitx(1'b1, r);
      desel();
      rd1(9'h020, v);
      chk("R6 partial write discarded", v, 8'h00);
      rdsr(v);
      chk("R6 latch kept after partial write", v, 8'h02);

      // R7 page wrap
      sel();
      byte_x(8'h02, d);
      byte_x(8'h2E, d);
      byte_x(8'hA1, d);
      byte_x(8'hA2, d);
      byte_x(8'hA3, d);
      desel();
      rd1(9'h02E, v);
      chk("R7 page byte 0x2E", v, 8'hA1);
      rd1(9'h02F, v);
      chk("R7 page byte 0x2F", v, 8'hA2);
      rd1(9'h020, v);
      chk("R7 wrapped to page start", v, 8'hA3);
      rd1(9'h030, v);
      chk("R7 next page untouched", v, 8'h00);

      // R2 unrecognised commands
      cmd1(8'h16);
      rdsr(v);
      chk("R2 nonzero upper nibble ignored", v, 8'h00);
      sel();
      byte_x(8'h07, d);
      byte_x(8'h00, d);
      chk("R2 unknown code drives no output", {7'd0, miso_oe}, 8'h00);
      desel();

      // R9 status write blocked by wp_n, then allowed
      wp_n = 1'b0;
      wrsr(8'hFF);
      wp_n = 1'b1;
      rdsr(v);
      chk("R9 blocked status write", v, 8'h02);
      wrsr(8'hFF);
      rdsr(v);
      chk("R9 protect bits loaded, latch cleared (R8)", v, 8'h0C);

      // R10 whole array protected
      wr1(9'h000, 8'h99);
      rd1(9'h000, v);
      chk("R10 protected write discarded", v, 8'h3C);
      rdsr(v);
      chk("R10 latch cleared by discarded write", v, 8'h0C);

      // R10 upper quarter
      wrsr(8'h04);
      rdsr(v);
      chk("R9 protect bits 01", v, 8'h04);
      wr1(9'h180, 8'h44);
      rd1(9'h180, v);
      chk("R10 quarter guarded", v, 8'h00);
      wr1(9'h17F, 8'h55);
      rd1(9'h17F, v);
      chk("R10 below quarter writable", v, 8'h55);

      // R11 hold in the middle of a read byte
      sel();
      byte_x(8'h0B, d);
      chk("R12 oe low in command phase", {7'd0, miso_oe}, 8'h00);
      byte_x(8'h7F, d);
      for (int i = 7; i >= 5; i--) bitx(1'b0, v[i]);
      hold_n = 1'b0;
      tick(3);
      chk("R11 oe low during hold", {7'd0, miso_oe}, 8'h00);
      for (int i = 0; i < 3; i++) begin
         sck = 1'b1; tick(3); sck = 1'b0; tick(3);
      end
      hold_n = 1'b1;
      tick(3);
      for (int i = 4; i >= 0; i--) bitx(1'b0, v[i]);
      desel();
      chk("R11 read resumes after hold", v, 8'h55);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule